// File: doc/BRIEF.md
# Bus Speed Tracker for a Passive USB Monitor

This block tells a passive bus monitor which rate its receiver should sample at: full speed or low speed. It watches a stream of already-decoded packet events and follows the way a host wraps low-speed traffic in a preamble. After a preamble the tracker drops to low speed. It returns to full speed once the low-speed transaction phase it expects has finished, or once the wire has been quiet for too long.

Transactions that send data to a device take two preamble-wrapped phases. The first phase carries the SETUP or OUT token and ends as soon as that token arrives. The second phase carries one DATA packet and then a handshake. Transactions that read from a device carry an IN token and the device's DATA packet inside one preamble window. A free-running tick at the full-speed bit rate drives the timeout counter. One low-speed bit time is taken as eight full-speed bit times. A static switch, passed through a synchroniser, pins the output at low speed on segments that only ever carry low-speed traffic.

Top module: `usb_speed_tracker`

## Requirements
- R1: While reset is held, and on the first cycle after it with the switch off, `ls_detect` is 0 (full speed).
- R2: Event codes on `pkt_kind` are 0 PRE, 1 SETUP, 2 OUT, 3 IN, 4 DATA and 5 handshake. A PRE seen at full speed raises `ls_detect` on the next clock edge.
- R3: The first low-speed token after a PRE, if it is SETUP or OUT, returns `ls_detect` to 0 on the edge that takes it.
- R4: After a SETUP or OUT phase, the next PRE opens a data phase. A DATA packet keeps low speed, and a following handshake returns to full speed. A handshake with no DATA before it also returns to full speed.
- R5: An IN token at low speed keeps `ls_detect` at 1. The DATA packet that follows it returns `ls_detect` to 0.
- R6: A handshake in any low-speed state returns `ls_detect` to 0 on the next edge.
- R7: When no event arrives at low speed, `ls_detect` falls on the 129th `bit_tick` (more than 16 low-speed bit times). Cycles without a tick do not advance the timeout.
- R8: While the tracker waits for DATA after an IN, the window is 18 low-speed bit times: `ls_detect` is still 1 after 144 ticks and falls on the 145th.
- R9: Any event taken at low speed, including one that leaves the state unchanged (a DATA or PRE while waiting for the first token), restarts the timeout count from zero.
- R10: `ls_detect` follows a rising `ls_only_sw` after two clock edges and then stays 1 regardless of events or ticks. After the switch falls, `ls_detect` returns to 0 two edges later, with the tracker at full speed.
- R11: At full speed, events other than PRE have no effect on `ls_detect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per full-speed bit time |
| ls_only_sw | input | 1 | Low-speed-only switch, asynchronous |
| pkt_valid | input | 1 | A decoded packet event is present this cycle |
| pkt_kind | input | 3 | Event code: 0 PRE, 1 SETUP, 2 OUT, 3 IN, 4 DATA, 5 handshake |
| ls_detect | output | 1 | 1 selects low-speed sampling, 0 selects full speed |

## Verification
The bench builds the tracker with its default parameters: eight full-speed ticks per low-speed bit, a 16-bit idle limit and an 18-bit IN-data limit. It drives `bit_tick` on every cycle during the timeout tests. This keeps the 129-tick and 145-tick boundaries within a few hundred cycles, so each boundary is checked on both sides: one tick before the limit and on the limit itself. The same small build keeps the two-stage switch synchroniser delay visible edge by edge.

// File: rtl/usb_spd_pkg.sv
// Shared types for the bus speed tracker.
package usb_spd_pkg;

    // Decoded packet event codes presented with pkt_valid.
    typedef enum logic [2:0] {
        EV_PRE   = 3'd0,
        EV_SETUP = 3'd1,
        EV_OUT   = 3'd2,
        EV_IN    = 3'd3,
        EV_DATA  = 3'd4,
        EV_HSK   = 3'd5
    } ev_kind_e;

    // Tracker states; every state other than ST_FULL samples at low speed.
    typedef enum logic [2:0] {
        ST_FULL        = 3'd0,
        ST_LS_TOKEN    = 3'd1,
        ST_LS_OUT_DATA = 3'd2,
        ST_LS_HSK      = 3'd3,
        ST_LS_IN_DATA  = 3'd4
    } spd_state_e;

endpackage

// File: rtl/usb_spd_sync.sv
// Multi-flop synchroniser for a slow static level.
// Assumes the input changes rarely and needs no pulse capture.
module usb_spd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/usb_spd_timer.sv
// Low-speed inactivity timer. It counts full-speed bit ticks since the last
// clear and flags expiry on the tick after the selected limit is reached.
// Assumes the controller clears it on every event and while it is idle.
module usb_spd_timer #(
    parameter int IDLE_TICKS = 128,
    parameter int LONG_TICKS = 144,
    localparam int MAX_TICKS = (IDLE_TICKS > LONG_TICKS) ? IDLE_TICKS : LONG_TICKS,
    localparam int CW        = $clog2(MAX_TICKS + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic long_win,
    output logic expired
);
    localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_TICKS);
    localparam logic [CW-1:0] LONG_LIM = CW'(LONG_TICKS);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Pick the window that applies to the current state.
    always_comb begin
        limit   = long_win ? LONG_LIM : IDLE_LIM;
        expired = tick && (cnt == limit);
    end

    // Count ticks; stop at the limit and restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clear)            cnt <= '0;
        else if (tick && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/usb_spd_fsm.sv
// Transaction follower. It enters low speed on a preamble and walks the
// token / data / handshake phases back to full speed. A pending flag
// remembers that a SETUP or OUT phase has been seen, so the next preamble
// opens the data phase. Assumes at most one event per cycle.
module usb_spd_fsm
    import usb_spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       ev_valid,
    input  logic [2:0] ev_kind,
    input  logic       expired,
    output spd_state_e state
);
    spd_state_e nxt_state;
    logic       pend_q, pend_d;
    ev_kind_e   kind;

    assign kind = ev_kind_e'(ev_kind);

    // Next state and pending flag; events take priority over expiry.
    always_comb begin
        nxt_state = state;
        pend_d    = pend_q;
        if (hold) begin
            nxt_state = ST_FULL;
            pend_d    = 1'b0;
        end else begin
            unique case (state)
                ST_FULL: begin
                    if (ev_valid && kind == EV_PRE) begin
                        nxt_state = pend_q ? ST_LS_OUT_DATA : ST_LS_TOKEN;
                        pend_d    = 1'b0;
                    end
                end
                ST_LS_TOKEN: begin
                    if (ev_valid) begin
                        case (kind)
                            EV_SETUP, EV_OUT: begin
                                nxt_state = ST_FULL;
                                pend_d    = 1'b1;
                            end
                            EV_IN:   nxt_state = ST_LS_IN_DATA;
                            EV_HSK:  nxt_state = ST_FULL;
                            default: nxt_state = ST_LS_TOKEN;
                        endcase
                    end else if (expired) begin
                        nxt_state = ST_FULL;
                    end
                end
                ST_LS_OUT_DATA: begin
                    if (ev_valid && kind == EV_DATA)     nxt_state = ST_LS_HSK;
                    else if (ev_valid && kind == EV_HSK) nxt_state = ST_FULL;
                    else if (!ev_valid && expired)       nxt_state = ST_FULL;
                end
                ST_LS_HSK: begin
                    if (ev_valid && kind == EV_HSK) nxt_state = ST_FULL;
                    else if (!ev_valid && expired)  nxt_state = ST_FULL;
                end
                ST_LS_IN_DATA: begin
                    if (ev_valid && (kind == EV_DATA || kind == EV_HSK)) nxt_state = ST_FULL;
                    else if (!ev_valid && expired)                       nxt_state = ST_FULL;
                end
                default: nxt_state = ST_FULL;
            endcase
        end
    end

    // State and pending flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FULL;
            pend_q <= 1'b0;
        end else begin
            state  <= nxt_state;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/usb_speed_tracker.sv
// Top of the bus speed tracker. It ties together the switch synchroniser,
// the transaction follower and the inactivity timer. Timeout windows are
// given in low-speed bit times and scaled to full-speed ticks.
// Assumes bit_tick pulses once per full-speed bit time.
module usb_speed_tracker
    import usb_spd_pkg::*;
#(
    parameter int LS_RATIO     = 8,
    parameter int IDLE_BITS    = 16,
    parameter int IN_DATA_BITS = 18,
    parameter int SYNC_STAGES  = 2,
    localparam int IDLE_TICKS  = IDLE_BITS * LS_RATIO,
    localparam int LONG_TICKS  = IN_DATA_BITS * LS_RATIO
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       ls_only_sw,
    input  logic       pkt_valid,
    input  logic [2:0] pkt_kind,
    output logic       ls_detect
);
    logic       sw_sync;
    logic       expired;
    logic       tmr_clear;
    logic       long_win;
    spd_state_e state;

    usb_spd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ls_only_sw),
        .q_sync  (sw_sync)
    );

    usb_spd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (sw_sync),
        .ev_valid (pkt_valid),
        .ev_kind  (pkt_kind),
        .expired  (expired),
        .state    (state)
    );

    // Timer runs only at low speed and restarts on every event.
    always_comb begin
        tmr_clear = pkt_valid || (state == ST_FULL) || sw_sync;
        long_win  = (state == ST_LS_IN_DATA);
    end

    usb_spd_timer #(.IDLE_TICKS(IDLE_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .tick     (bit_tick),
        .long_win (long_win),
        .expired  (expired)
    );

    // Rate select: forced by the switch, otherwise by the follower state.
    assign ls_detect = sw_sync || (state != ST_FULL);
endmodule

// File: rtl/usb_spd_checker.sv
// Protocol checks for the bus speed tracker, bound to its top module.
module usb_spd_checker
    import usb_spd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sw_sync,
    input logic       pkt_valid,
    input logic [2:0] pkt_kind,
    input spd_state_e state,
    input logic       ls_detect
);
    p_pre_enters_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !sw_sync && pkt_valid && pkt_kind == EV_PRE) |=> ls_detect);

    p_in_data_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LS_IN_DATA && !sw_sync && pkt_valid && pkt_kind == EV_DATA)
        |=> (!ls_detect || sw_sync));

    p_hsk_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FULL && !sw_sync && pkt_valid && pkt_kind == EV_HSK)
        |=> (!ls_detect || sw_sync));

    p_switch_holds_fsm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sync |=> (state == ST_FULL));

    p_fs_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_detect && pkt_valid && pkt_kind != EV_PRE) |=> (!ls_detect || sw_sync));
endmodule

bind usb_speed_tracker usb_spd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_sync   (sw_sync),
    .pkt_valid (pkt_valid),
    .pkt_kind  (pkt_kind),
    .state     (state),
    .ls_detect (ls_detect)
);

// File: tb/usb_speed_tracker_test.sv
module usb_speed_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       ls_only_sw = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [2:0] pkt_kind = 3'd0;
    logic       ls_detect;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    usb_speed_tracker uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ls_only_sw(ls_only_sw),
        .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .ls_detect(ls_detect)
    );

    // Vector: {req[3:0], valid, kind[2:0], tick, expected ls_detect}
    localparam int NV = 22;
    localparam logic [9:0] VECS [NV] = '{
        10'b0001_0_000_0_0,  // R1 idle after reset
        10'b0010_1_000_0_1,  // R2 PRE
        10'b0011_1_001_0_0,  // R3 SETUP returns
        10'b0100_1_000_0_1,  // R4 PRE opens data phase
        10'b0100_1_100_0_1,  // R4 DATA stays low speed
        10'b0100_0_000_0_1,  // R4 idle
        10'b0100_1_101_0_0,  // R4 handshake returns
        10'b0010_1_000_0_1,  // R2 PRE
        10'b0101_1_011_0_1,  // R5 IN stays
        10'b0101_1_100_0_0,  // R5 DATA returns
        10'b0010_1_000_0_1,  // R2 PRE
        10'b0110_1_101_0_0,  // R6 handshake returns
        10'b1011_1_100_0_0,  // R11 DATA at full speed ignored
        10'b1011_1_101_0_0,  // R11 handshake ignored
        10'b1011_1_011_0_0,  // R11 IN ignored
        10'b0010_1_000_0_1,  // R2 PRE
        10'b0011_1_010_0_0,  // R3 OUT returns
        10'b0100_1_000_0_1,  // R4 PRE opens data phase
        10'b0100_1_101_0_0,  // R4 handshake without data
        10'b0010_1_000_0_1,  // R2 PRE, pending consumed
        10'b0101_1_011_0_1,  // R5 IN
        10'b0110_1_101_0_0   // R6 handshake while waiting for data
    };

    task automatic apply(input logic v, input logic [2:0] k, input logic t);
        pkt_valid = v;
        pkt_kind  = k;
        bit_tick  = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        checks++;
        if (ls_detect !== exp) begin
            fails++;
            $display("FAIL %s: ls_detect=%b expected %b", req, ls_detect, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) apply(1'b0, 3'd0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply(1'b0, 3'd0, 1'b0);
        check(1'b0, "R1 during reset");
        apply(1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        apply(1'b0, 3'd0, 1'b0);
        check(1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][5], VECS[i][4:2], VECS[i][1]);
            check(VECS[i][0], $sformatf("R%0d vector %0d", VECS[i][9:6], i));
        end

        // R7: idle timeout boundary
        apply(1'b1, 3'd0, 1'b0);
        ticks(128);
        check(1'b1, "R7 after 128 ticks");
        ticks(1);
        check(1'b0, "R7 on tick 129");

        // R7: cycles without tick do not advance
        apply(1'b1, 3'd0, 1'b0);
        for (int i = 0; i < 300; i++) apply(1'b0, 3'd0, 1'b0);
        check(1'b1, "R7 no tick no timeout");
        apply(1'b1, 3'd5, 1'b0);
        check(1'b0, "R6 handshake after long wait");

        // R8: IN data window
        apply(1'b1, 3'd0, 1'b0);
        apply(1'b1, 3'd3, 1'b0);
        ticks(144);
        check(1'b1, "R8 after 144 ticks");
        ticks(1);
        check(1'b0, "R8 on tick 145");

        // R9: an ignored DATA restarts the count
        apply(1'b1, 3'd0, 1'b0);
        ticks(100);
        apply(1'b1, 3'd4, 1'b0);
        check(1'b1, "R9 DATA while waiting for token");
        ticks(128);
        check(1'b1, "R9 count restarted");
        ticks(1);
        check(1'b0, "R9 timeout after restart");

        // R10: low-speed-only switch
        ls_only_sw = 1'b1;
        apply(1'b0, 3'd0, 1'b0);
        check(1'b0, "R10 one edge after switch");
        apply(1'b0, 3'd0, 1'b0);
        check(1'b1, "R10 two edges after switch");
        apply(1'b1, 3'd5, 1'b0);
        check(1'b1, "R10 handshake ignored");
        apply(1'b1, 3'd0, 1'b0);
        ticks(200);
        check(1'b1, "R10 no timeout while forced");
        ls_only_sw = 1'b0;
        apply(1'b0, 3'd0, 1'b0);
        check(1'b1, "R10 one edge after release");
        apply(1'b0, 3'd0, 1'b0);
        check(1'b0, "R10 full speed after release");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule